// File: doc/BRIEF.md
# Width-Degradable Flit Lane Serializer

This block is the transmit half of a 20-lane point-to-point link. Each flit it accepts carries an 8-bit header and a 64-bit payload. The block adds an 8-bit CRC to make an 80-bit flit. It then sends the flit as a series of lane transfers, two transfers per clock, presented as a 40-bit double-data-rate word. The 20 lanes form four quadrants of five lanes each.

When lanes fail, the link can keep running at reduced width. The width code selects one of three widths:
- full width uses all four quadrants;
- half width uses two quadrants;
- quarter width uses one quadrant.

A quadrant mask lists the healthy quadrants, and data is steered onto the lowest healthy ones. The flit format is the same in every width. Only the number of clocks per flit and the lane steering change.

Flow control is ready/valid. Ready is raised in the last clock of the current flit, so back-to-back flits leave no idle clock. A flit uses the configuration that was present on the inputs in the clock it was accepted. A mask with too few healthy quadrants blocks all traffic and raises an error flag.

Top module: `flit_lane_tx`

## Requirements
- R1: The flit holds the payload in bits [63:0], the header in [71:64] and the CRC in [79:72]. The CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0. It is computed over {header, payload}, starting from bit 71 and moving toward bit 0.
- R2: Transfer k of a flit carries flit bits [k*L +: L], where L is the active lane count (20, 10 or 5). In each clock, lane_ddr[19:0] is the first transfer of the pair and lane_ddr[39:20] is the second. The first pair appears in the clock after acceptance.
- R3: Width code 0 (full, mask must be 4'b1111) takes 2 clocks per flit. Five-lane group g goes to lanes [5g+4:5g] of each transfer.
- R4: Width code 1 (half) takes 4 clocks per flit. Group 0 goes to the lowest set bit of the mask and group 1 to the next set bit. All other quadrants drive zero.
- R5: Width code 2 (quarter) takes 8 clocks per flit. The single group goes to the lowest set bit of the mask. All other quadrants drive zero.
- R6: in_ready is high when the block is idle and in the clock that drives the last pair of a flit, and low in every other clock. A flit held valid is therefore sent with no gap.
- R7: Width and mask are captured when a flit is accepted. A change during a flit leaves that flit's beats unchanged.
- R8: in_ready stays low while the inputs request width code 3, or a width whose quadrant count exceeds the number of mask bits set. When this is seen at a flit boundary, cfg_err goes high one clock later. It goes low one clock after a valid configuration is seen at a boundary.
- R9: After reset and whenever no flit is in progress, lane_ddr is zero and cfg_err is zero unless R8 sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Width code: 0 full, 1 half, 2 quarter, 3 invalid |
| cfg_qmask | input | 4 | Healthy-quadrant mask, bit q for quadrant q |
| cfg_err | output | 1 | Configuration cannot carry the requested width |
| in_valid | input | 1 | Flit offered |
| in_ready | output | 1 | Flit accepted on this clock edge if valid |
| in_hdr | input | 8 | Link header of the flit |
| in_payload | input | 64 | Payload of the flit |
| lane_ddr | output | 40 | Two lane transfers per clock: [19:0] first, [39:20] second |

## Verification
Two events can fall in the same clock. One is driving the last beat pair of one flit. The other is accepting the next flit, whose configuration differs. To provoke this, the bench offers a second flit with a new width and mask while the first is still in flight, and holds it until the boundary. The bench then checks that every pair of the first flit keeps the old steering. It also checks that the second flit starts on the very next clock with the new beat count and quadrant choice, and that ready was low until the last pair.

// File: rtl/flit_tx_pkg.sv
package flit_tx_pkg;
    localparam int QUADS  = 4;
    localparam int QLANES = 5;
    localparam int HDR_W  = 8;
    localparam int PAY_W  = 64;
    localparam int CRC_W  = 8;

    typedef enum logic [1:0] {
        W_FULL    = 2'd0,
        W_HALF    = 2'd1,
        W_QUARTER = 2'd2,
        W_BAD     = 2'd3
    } width_e;

    function automatic int groups_for(width_e w, int nq);
        case (w)
            W_FULL:    return nq;
            W_HALF:    return nq / 2;
            W_QUARTER: return nq / 4;
            default:   return 0;
        endcase
    endfunction
endpackage

// File: rtl/flit_crc8.sv
module flit_crc8 #(
    parameter int          DW   = 72,
    parameter logic [7:0]  POLY = 8'h07
) (
    input  logic [DW-1:0] data,
    output logic [7:0]    crc
);
    always_comb begin
        logic [7:0] c;
        logic       fb;
        c = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = c[7] ^ data[i];
            c  = {c[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
        end
        crc = c;
    end
endmodule

// File: rtl/quad_steer.sv
module quad_steer
    import flit_tx_pkg::*;
#(
    parameter int NQ = QUADS,
    parameter int QL = QLANES,
    localparam int LW = NQ * QL
) (
    input  width_e        mode,
    input  logic [NQ-1:0] mask,
    input  logic [LW-1:0] slice,
    output logic [LW-1:0] lanes
);
    int groups;
    assign groups = groups_for(mode, NQ);

    for (genvar q = 0; q < NQ; q++) begin : g_quad
        always_comb begin
            int rank;
            rank = 0;
            for (int j = 0; j < q; j++) rank += int'(mask[j]);
            if (mask[q] && rank < groups)
                lanes[q*QL +: QL] = slice[rank*QL +: QL];
            else
                lanes[q*QL +: QL] = '0;
        end
    end
endmodule

// File: rtl/flit_lane_tx.sv
module flit_lane_tx
    import flit_tx_pkg::*;
#(
    parameter int NQ  = QUADS,
    parameter int QL  = QLANES,
    parameter int HW  = HDR_W,
    parameter int PW  = PAY_W,
    parameter int CW  = CRC_W,
    localparam int LANES  = NQ * QL,
    localparam int FLIT_W = CW + HW + PW,
    localparam int MAXP   = FLIT_W / (2 * QL),
    localparam int PIDX_W = $clog2(MAXP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic [NQ-1:0]     cfg_qmask,
    output logic              cfg_err,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HW-1:0]     in_hdr,
    input  logic [PW-1:0]     in_payload,
    output logic [2*LANES-1:0] lane_ddr
);
    typedef struct packed {
        logic              busy;
        logic [PIDX_W-1:0] pidx;
        logic [FLIT_W-1:0] flit;
        width_e            mode;
        logic [NQ-1:0]     mask;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    width_e            req_mode;
    logic              err_now, last_pair, boundary, accept;
    logic [CW-1:0]     crc_val;
    logic [PIDX_W-1:0] last_idx;
    int                gq;
    logic [LANES-1:0]  beat0_raw, beat1_raw, beat0_st, beat1_st;

    assign req_mode = width_e'(cfg_width);
    assign err_now  = (req_mode == W_BAD) ||
                      ($countones(cfg_qmask) < groups_for(req_mode, NQ));

    flit_crc8 #(.DW(HW + PW)) u_crc (
        .data ({in_hdr, in_payload}),
        .crc  (crc_val)
    );

    always_comb begin
        gq = groups_for(st_q.mode, NQ);
        if (gq < 1) gq = 1;
        last_idx = PIDX_W'(FLIT_W / (2 * QL * gq) - 1);
    end

    assign last_pair = st_q.busy && (st_q.pidx == last_idx);
    assign boundary  = !st_q.busy || last_pair;
    assign in_ready  = boundary && !err_now;
    assign accept    = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) st_d.pidx = st_q.pidx + 1'b1;
        if (last_pair) st_d.busy = 1'b0;
        if (boundary)  st_d.err  = err_now;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.pidx = '0;
            st_d.flit = {crc_val, in_hdr, in_payload};
            st_d.mode = req_mode;
            st_d.mask = cfg_qmask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= W_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        int sh;
        sh        = int'(st_q.pidx) * 2 * gq * QL;
        beat0_raw = LANES'(st_q.flit >> sh);
        beat1_raw = LANES'(st_q.flit >> (sh + gq * QL));
    end

    quad_steer #(.NQ(NQ), .QL(QL)) u_steer0 (
        .mode (st_q.mode), .mask (st_q.mask), .slice (beat0_raw), .lanes (beat0_st)
    );
    quad_steer #(.NQ(NQ), .QL(QL)) u_steer1 (
        .mode (st_q.mode), .mask (st_q.mask), .slice (beat1_raw), .lanes (beat1_st)
    );

    assign lane_ddr = st_q.busy ? {beat1_st, beat0_st} : '0;
    assign cfg_err  = st_q.err;

    // R2: an accepted flit starts at pair zero in the next clock
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q.busy && st_q.pidx == '0));

    // R6: acceptance during a flit continues without an idle clock
    p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q.busy) |=> st_q.busy);

    // R7: captured configuration and flit stay fixed mid-flit
    p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !last_pair) |=>
            ($stable(st_q.mode) && $stable(st_q.mask) && $stable(st_q.flit)));

    // R8: the error flag only rises after a clock in which nothing was accepted
    p_err_noaccept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(!in_ready));

    // R9: no lane activity while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> (lane_ddr == '0));

    // R4 / R5: quadrants outside the mask stay silent
    for (genvar q = 0; q < NQ; q++) begin : g_chk
        p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.busy && !st_q.mask[q]) |->
                (lane_ddr[q*QL +: QL] == '0 && lane_ddr[LANES + q*QL +: QL] == '0));
    end
endmodule

// File: tb/flit_lane_tx_test.sv
module flit_lane_tx_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic [3:0]  cfg_qmask = 4'b1111;
    logic        cfg_err;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_hdr = '0;
    logic [63:0] in_payload = '0;
    logic [39:0] lane_ddr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flit_lane_tx uut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_qmask(cfg_qmask),
        .cfg_err(cfg_err), .in_valid(in_valid), .in_ready(in_ready),
        .in_hdr(in_hdr), .in_payload(in_payload), .lane_ddr(lane_ddr)
    );

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [71:0] m);
        logic [7:0] r = 8'h00;
        for (int i = 71; i >= 0; i--) begin
            logic top = r[7] ^ m[i];
            r = r << 1;
            if (top) r = r ^ 8'h07;
        end
        return r;
    endfunction

    function automatic int ngroups(input int w);
        return (w == 0) ? 4 : (w == 1) ? 2 : 1;
    endfunction

    function automatic logic [39:0] ref_pair(input logic [79:0] f, input int w,
                                             input logic [3:0] m, input int p);
        logic [39:0] o = '0;
        int g_n = ngroups(w);
        int l = g_n * 5;
        for (int b = 0; b < 2; b++) begin
            int base = (2 * p + b) * l;
            int g = 0;
            for (int q = 0; q < 4; q++) begin
                if (m[q] && g < g_n) begin
                    for (int k = 0; k < 5; k++) o[b*20 + q*5 + k] = f[base + g*5 + k];
                    g++;
                end
            end
        end
        return o;
    endfunction

    function automatic logic [79:0] mk_flit(input logic [7:0] h, input logic [63:0] p);
        return {ref_crc({h, p}), h, p};
    endfunction

    function automatic logic [63:0] pay_of(input int seed);
        return {32'(seed * 32'h9E3779B9), 32'(seed * 32'h85EBCA6B + 7)};
    endfunction

    // R1 R2 R3 R4 R5 R6 R9: stream n flits back to back in one configuration
    task automatic stream(input int n, input int w, input logic [3:0] m, input int seed, input string req);
        int np = 80 / (2 * ngroups(w) * 5);
        logic [79:0] fl [8];
        for (int i = 0; i < n; i++) fl[i] = mk_flit(8'(seed + i * 17), pay_of(seed + i));
        @(negedge clk);
        cfg_width = 2'(w); cfg_qmask = m;
        in_valid = 1'b1; in_hdr = fl[0][71:64]; in_payload = fl[0][63:0];
        #1 chk(in_ready === 1'b1, {req, " R6 idle ready"}, 80'(in_ready), 80'd1);
        for (int i = 0; i < n; i++) begin
            for (int p = 0; p < np; p++) begin
                @(negedge clk);
                chk(lane_ddr === ref_pair(fl[i], w, m, p), {req, " R1 R2 beat pair"},
                    80'(lane_ddr), 80'(ref_pair(fl[i], w, m, p)));
                if (p == 0) begin
                    if (i + 1 < n) begin
                        in_hdr = fl[i+1][71:64]; in_payload = fl[i+1][63:0];
                    end else in_valid = 1'b0;
                end
                chk(in_ready === (p == np - 1), {req, " R6 ready timing"},
                    80'(in_ready), 80'(p == np - 1));
            end
        end
        @(negedge clk);
        chk(lane_ddr === 40'd0, {req, " R9 idle zero"}, 80'(lane_ddr), 80'd0);
    endtask

    // R7: next flit offered with a new configuration while one is in flight
    task automatic mid_change();
        logic [79:0] fa = mk_flit(8'hA5, 64'h0123_4567_89AB_CDEF);
        logic [79:0] fb = mk_flit(8'h3C, 64'hFEDC_BA98_7654_3210);
        @(negedge clk);
        cfg_width = 2'd1; cfg_qmask = 4'b1111;
        in_valid = 1'b1; in_hdr = fa[71:64]; in_payload = fa[63:0];
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            chk(lane_ddr === ref_pair(fa, 1, 4'b1111, p), "R7 old flit keeps old steering",
                80'(lane_ddr), 80'(ref_pair(fa, 1, 4'b1111, p)));
            if (p == 0) begin
                cfg_width = 2'd2; cfg_qmask = 4'b0100;
                in_hdr = fb[71:64]; in_payload = fb[63:0];
                #1;
            end
            chk(in_ready === (p == 3), "R7 R6 held until boundary", 80'(in_ready), 80'(p == 3));
        end
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            chk(lane_ddr === ref_pair(fb, 2, 4'b0100, p), "R7 R5 new flit uses new cfg",
                80'(lane_ddr), 80'(ref_pair(fb, 2, 4'b0100, p)));
            if (p == 0) in_valid = 1'b0;
        end
        @(negedge clk);
        chk(lane_ddr === 40'd0, "R9 idle after change", 80'(lane_ddr), 80'd0);
    endtask

    // R8: insufficient mask and invalid code block traffic
    task automatic cfg_fault();
        @(negedge clk);
        cfg_width = 2'd1; cfg_qmask = 4'b0100;
        in_valid = 1'b1; in_hdr = 8'h11; in_payload = 64'h1;
        #1 chk(in_ready === 1'b0, "R8 ready low on short mask", 80'(in_ready), 80'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(cfg_err === 1'b1, "R8 error flag", 80'(cfg_err), 80'd1);
            chk(lane_ddr === 40'd0 && in_ready === 1'b0, "R8 nothing sent",
                80'(lane_ddr), 80'd0);
        end
        cfg_width = 2'd3; cfg_qmask = 4'b1111;
        #1 chk(in_ready === 1'b0, "R8 code 3 rejected", 80'(in_ready), 80'd0);
        @(negedge clk);
        chk(cfg_err === 1'b1, "R8 code 3 keeps error", 80'(cfg_err), 80'd1);
        in_valid = 1'b0; cfg_width = 2'd0; cfg_qmask = 4'b1110;
        #1 chk(in_ready === 1'b0, "R8 R3 full needs all quads", 80'(in_ready), 80'd0);
        cfg_width = 2'd2; cfg_qmask = 4'b1000;
        #1 chk(in_ready === 1'b1 && cfg_err === 1'b1, "R8 ready on fix, flag still set",
               80'({in_ready, cfg_err}), 80'b11);
        @(negedge clk);
        chk(cfg_err === 1'b0, "R8 flag clears", 80'(cfg_err), 80'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(lane_ddr === 40'd0, "R9 reset lanes", 80'(lane_ddr), 80'd0);
        chk(cfg_err === 1'b0, "R9 reset error flag", 80'(cfg_err), 80'd0);
        rst_n = 1'b1;
        chk(ref_crc(72'h0) === 8'h00, "R1 crc of zero", 80'(ref_crc(72'h0)), 80'd0);
        stream(3, 0, 4'b1111, 5, "R3 full");
        stream(2, 1, 4'b1111, 40, "R4 half low");
        stream(2, 1, 4'b1010, 70, "R4 half sparse");
        stream(1, 2, 4'b1000, 90, "R5 quarter top");
        stream(2, 2, 4'b0110, 99, "R5 quarter mid");
        mid_change();
        cfg_fault();
        stream(1, 2, 4'b1000, 123, "R8 after recovery");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule